// File: doc/BRIEF.md
# Iterative Factorial Coprocessor

This block computes the factorial of an unsigned 32-bit operand supplied by software, keeping only the low 32 bits of the product. The work is done over several clock cycles, with one multiplication per cycle. While the computation runs, a busy flag is visible in the status word. Software either polls that flag or waits for the completion interrupt request.

Writing the operand starts a computation, but only when the unit is idle. A write that arrives while the unit is busy is dropped and does not disturb the run in progress. The status word also holds an interrupt-enable bit that software can write. When that bit is set at the moment a run finishes, the block pulses a request line toward an external interrupt status unit, which treats it as its pending bit 0. Bus address decoding and the aggregation of interrupts belong to the surrounding logic.

Top module: `factorial_engine`

## Requirements
- R1: After reset the status word reads 0 (busy clear, enable clear), the done request is low, and the result reads 1.
- R2: An operand write while idle is accepted. Status bit 0 (busy) reads 1 from the cycle after the write and stays 1 for exactly max(n,1) cycles, then reads 0.
- R3: An operand write while busy is ignored: the run in progress keeps its original operand, its duration and its result.
- R4: Once busy has cleared, the result reads n! modulo 2^32, with 0! = 1. The result holds that value until the next accepted operand write. For any n of 34 or more the result is 0.
- R5: Writing the status word sets status bit 7 (interrupt enable) when bit 7 of the written value is 1, and clears it when that bit is 0. Status bits other than 0 and 7 always read 0.
- R6: A status write never changes the busy bit, whatever value is written and whether the unit is idle or busy.
- R7: If the enable bit is 1 at the clock edge where busy falls, the done request is high for exactly the one cycle that follows that edge.
- R8: If the enable bit is 0 at the clock edge where busy falls, the done request stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opWrEn | input | 1 | Operand write strobe |
| opWrData | input | 32 | Operand value n |
| statWrEn | input | 1 | Status write strobe |
| statWrData | input | 32 | Status write value; only bit 7 is used |
| statRd | output | 32 | Status word: bit 0 busy, bit 7 interrupt enable |
| result | output | 32 | Factorial result, low 32 bits |
| doneIrq | output | 1 | Single-cycle completion interrupt request |

## Verification
The hardest situations to produce from the ports are collisions with a run in progress. These are a second operand write, and status writes that try to clear busy or that flip the enable bit. They only exist inside the window where busy is high. The bench starts a long run (n = 10) and, at known cycle offsets inside that window, drives a competing operand, a status value with bit 0 set, and an enable change. It then checks that the original result survives and that the request follows the enable value in force at the completion edge. Operands of 33 and 34 exercise the point where the truncated product first becomes zero.

// File: rtl/fe_pkg.sv
package fe_pkg;
  localparam int DATA_W   = 32;
  localparam int BUSY_BIT = 0;
  localparam int IEN_BIT  = 7;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // seed accumulator and counter with a new operand
    logic step;   // one multiply-and-decrement iteration
  } fe_strb_t;
endpackage

// File: rtl/fe_datapath.sv
module fe_datapath
  import fe_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  fe_strb_t     strb,
  input  logic [W-1:0] opIn,
  output logic [W-1:0] acc,
  output logic         lastN
);
  logic [W-1:0] cnt;
  logic [W-1:0] prod;

  always_comb prod = acc * cnt;

  // counter at 0 or 1 means nothing left to multiply
  always_comb lastN = (cnt[W-1:1] == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= W'(1);
      cnt <= '0;
    end else if (strb.load) begin
      acc <= W'(1);
      cnt <= opIn;
    end else if (strb.step) begin
      acc <= prod;
      cnt <= cnt - W'(1);
    end
  end

  // R4: the result is frozen whenever no strobe is issued
  a_r4_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.step) |=> $stable(acc));

  // R2: control never steps once the counter has run out
  a_r2_no_step_past_end: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |-> !lastN);
endmodule

// File: rtl/fe_ctrl.sv
module fe_ctrl
  import fe_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     opWrEn,
  input  logic     statWrEn,
  input  logic     statWrIen,
  input  logic     lastN,
  output fe_strb_t strb,
  output logic     busy,
  output logic     ien,
  output logic     doneIrq
);
  logic finish;

  always_comb begin
    strb.load = opWrEn && !busy;   // operand dropped while busy
    strb.step = busy && !lastN;
    finish    = busy && lastN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      ien     <= 1'b0;
      doneIrq <= 1'b0;
    end else begin
      if (strb.load)   busy <= 1'b1;
      else if (finish) busy <= 1'b0;
      if (statWrEn)    ien  <= statWrIen;
      doneIrq <= finish && ien;
    end
  end

  // R3: no new load can be issued during a run
  a_r3_no_reload_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.load);

  // R2: an accepted operand write raises busy next cycle
  a_r2_busy_rises: assert property (@(posedge clk) disable iff (!rstN)
    (opWrEn && !busy) |=> busy);

  // R7: the request appears only on the edge where busy fell
  a_r7_irq_at_fall: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> (!busy && $past(busy)));

  // R7: the request lasts a single cycle
  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq);

  // R6: a status write by itself never moves busy
  a_r6_stat_keeps_busy: assert property (@(posedge clk) disable iff (!rstN)
    (statWrEn && !opWrEn && busy && !lastN) |=> busy);
endmodule

// File: rtl/factorial_engine.sv
module factorial_engine
  import fe_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opWrEn,
  input  logic [31:0] opWrData,
  input  logic        statWrEn,
  input  logic [31:0] statWrData,
  output logic [31:0] statRd,
  output logic [31:0] result,
  output logic        doneIrq
);
  fe_strb_t strb;
  logic     lastN;
  logic     busy;
  logic     ien;

  fe_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .opWrEn    (opWrEn),
    .statWrEn  (statWrEn),
    .statWrIen (statWrData[IEN_BIT]),
    .lastN     (lastN),
    .strb      (strb),
    .busy      (busy),
    .ien       (ien),
    .doneIrq   (doneIrq)
  );

  fe_datapath #(.W(DATA_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .opIn  (opWrData),
    .acc   (result),
    .lastN (lastN)
  );

  always_comb begin
    statRd           = '0;
    statRd[BUSY_BIT] = busy;
    statRd[IEN_BIT]  = ien;
  end

  // R5: unused status bits read zero
  a_r5_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
    (statRd & 32'hFFFF_FF7E) == 32'h0);
endmodule

// File: tb/factorial_engine_bench.sv
module factorial_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;
  localparam int unsigned VN[NV] = '{0, 1, 2, 5, 7, 10, 12, 13, 34};
  localparam logic [31:0] VX[NV] = '{32'd1, 32'd1, 32'd2, 32'd120, 32'd5040,
                                     32'd3628800, 32'd479001600, 32'd1932053504, 32'd0};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opWrEn = 1'b0;
  logic [31:0] opWrData = '0;
  logic        statWrEn = 1'b0;
  logic [31:0] statWrData = '0;
  logic [31:0] statRd;
  logic [31:0] result;
  logic        doneIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  factorial_engine u_factorial_engine (
    .clk(clk), .rstN(rstN), .opWrEn(opWrEn), .opWrData(opWrData),
    .statWrEn(statWrEn), .statWrData(statWrData), .statRd(statRd),
    .result(result), .doneIrq(doneIrq)
  );

  function automatic logic [31:0] refFact(int unsigned n);
    logic [31:0] p = 32'd1;
    for (int unsigned k = 2; k <= n; k++) p = p * k;
    return p;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic setIen(bit v);
    @(negedge clk);
    statWrEn = 1'b1; statWrData = v ? 32'h80 : 32'h0;
    @(negedge clk);
    statWrEn = 1'b0;
  endtask

  task automatic startOp(logic [31:0] n);
    @(negedge clk);
    opWrData = n; opWrEn = 1'b1;
    @(negedge clk);
    opWrEn = 1'b0;
  endtask

  task automatic waitIdle(output int cycles);
    cycles = 0;
    while (statRd[0] && cycles < 2000) begin
      cycles++;
      @(negedge clk);
    end
  endtask

  task automatic finishRun();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
      finishRun();
    end
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(statRd == 32'h0, "R1 status", statRd, 32'h0);
    check(doneIrq == 1'b0, "R1 irq", {31'd0, doneIrq}, 32'd0);
    check(result == 32'd1, "R1 result", result, 32'd1);

    // table walk: R2 R4 R5 R7 R8
    for (int i = 0; i < NV; i++) begin
      bit en = (i % 2) == 1;
      setIen(en);
      check(statRd[7] == en, "R5 enable readback", statRd, {24'd0, en, 7'd0});
      startOp(VN[i]);
      check(statRd[0] == 1'b1, "R2 busy rise", statRd, 32'd1);
      waitIdle(cyc);
      check(cyc == ((VN[i] == 0) ? 1 : int'(VN[i])), "R2 busy length", cyc,
            (VN[i] == 0) ? 1 : VN[i]);
      check(result == VX[i], "R4 result", result, VX[i]);
      if (en) check(doneIrq == 1'b1, "R7 irq pulse", {31'd0, doneIrq}, 32'd1);
      else    check(doneIrq == 1'b0, "R8 irq quiet", {31'd0, doneIrq}, 32'd0);
      @(negedge clk);
      check(doneIrq == 1'b0, "R7 irq single", {31'd0, doneIrq}, 32'd0);
      check(result == VX[i], "R4 result hold", result, VX[i]);
    end

    // R4 edge of truncation, checked against bench model; R8 with enable clear
    setIen(1'b0);
    startOp(32'd33);
    waitIdle(cyc);
    check(result == refFact(33) && result != 0, "R4 n=33", result, refFact(33));
    check(doneIrq == 1'b0, "R8 no irq", {31'd0, doneIrq}, 32'd0);
    startOp(32'd20);
    waitIdle(cyc);
    check(result == refFact(20), "R4 n=20", result, refFact(20));

    // R6: status write while idle with bit 0 set leaves busy clear
    @(negedge clk);
    statWrEn = 1'b1; statWrData = 32'hFFFF_FF7F;
    @(negedge clk);
    statWrEn = 1'b0;
    check(statRd == 32'h0, "R6 idle busy kept / R5 clear", statRd, 32'h0);

    // R3 R6 R7: collisions during a run of n=10
    setIen(1'b1);
    startOp(32'd10);
    @(negedge clk); @(negedge clk);
    opWrEn = 1'b1; opWrData = 32'd3;
    @(negedge clk);
    opWrEn = 1'b0;
    check(statRd[0] == 1'b1, "R3 still busy", statRd, 32'd1);
    statWrEn = 1'b1; statWrData = 32'h0000_0001;   // clears enable, tries busy
    @(negedge clk);
    check(statRd == 32'h1, "R6 busy kept, enable cleared", statRd, 32'h1);
    statWrData = 32'h0000_0080;                    // enable back on
    @(negedge clk);
    statWrEn = 1'b0;
    check(statRd == 32'h81, "R6 busy kept, enable set", statRd, 32'h81);
    waitIdle(cyc);
    check(cyc == 5, "R3 original duration", cyc, 32'd5);
    check(result == 32'd3628800, "R3 original result", result, 32'd3628800);
    check(doneIrq == 1'b1, "R7 irq after enable restored", {31'd0, doneIrq}, 32'd1);
    @(negedge clk);
    check(doneIrq == 1'b0, "R7 single pulse", {31'd0, doneIrq}, 32'd0);

    finishRun();
  end
endmodule